// File: doc/BRIEF.md
# Address Window Decoder

This block sorts 32-bit memory addresses from a data-moving engine into eight programmable address windows. Each window has a base page and a size mask, both at 64 KiB granularity. It also carries an 8-bit attribute and a 4-bit target identifier, which the downstream interconnect uses to route the access. A lookup port takes an address, a read/write direction and a channel number. In the same cycle, with no register in the path, it returns whether a window matched, which one, its target and attribute, and whether the access direction is permitted. When no enabled window claims the address, it raises a decode-error flag.

Software, or a configuration sequencer, programs the windows through a simple register port. A write is taken at a rising clock edge, and the read data is a combinational view of the stored registers. Each channel has its own enable register. That register turns windows on for that channel and holds a two-bit access field per window. Each channel also has an override register, and the first four windows have a high-remap register. These registers are only stored and read back; they do not change the lookup.

Top module: `awd_decoder`

## Requirements
- R1: After the asynchronous active-low reset, every register offset reads 0 and a lookup of any address reports lk_hit=0 and lk_dec_err=1.
- R2: The base register of window i lives at offset i (0..7). It keeps the base page in [31:16], the attribute in [15:8] and the target identifier in [3:0]. Bits [7:4] always read as zero.
- R3: The size register of window i lives at offset 8+i and holds the window size minus one. Only bits [31:16] are kept, and bits [15:0] always read as zero.
- R4: Window i matches when bit i of the selected enable register is 1 and (lk_addr[31:16] AND NOT size[31:16]) equals base[31:16]. A match drives lk_hit=1, lk_win=i, lk_target and lk_attr from that window's base register.
- R5: When several windows match, the lowest-numbered one is reported.
- R6: When no enabled window matches, lk_hit=0 and lk_dec_err=1. In that case lk_win, lk_target, lk_attr and lk_perm_err are all 0.
- R7: Bits [17+2i:16+2i] of an enable register are window i's access field. The lower bit permits reads and the upper bit permits writes. A disallowed direction on the winning window sets lk_perm_err=1, while lk_hit stays 1 and the window fields are still reported.
- R8: Offset 20 is channel 0's enable register and offset 21 is channel 1's. A lookup uses the one chosen by lk_chan. Bits [15:8] of an enable register read as zero.
- R9: The high-remap registers of windows 0..3 (offsets 16..19) and the override registers of channel 0 and channel 1 (offsets 22 and 23) store and return all 32 bits.
- R10: Offsets 24..31 read as 0, and writes to them change no register and no lookup result.
- R11: A register write takes effect at the rising edge. During the cycle of the write, a lookup still reflects the old contents; from the next cycle it reflects the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| lk_addr | input | 32 | Address to decode |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_chan | input | 1 | Channel whose enable register applies |
| lk_hit | output | 1 | Some enabled window matched |
| lk_win | output | 3 | Index of the winning window |
| lk_target | output | 4 | Target identifier of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_dec_err | output | 1 | No enabled window matched |
| lk_perm_err | output | 1 | Access direction refused by the winning window |

## Verification
A register write and an address lookup can fall in the same cycle. In the interesting case, the write moves the very window the lookup is hitting. The bench provokes this by rebasing window 0 while looking up an address inside its old range. It judges the result before the edge, where the old hit must still be reported, and after the edge, where the old address must miss and the new range must hit. The same pairing with permission bits shows up in the vector table, because reads and writes of one address are decoded against the same enable register that software may be rewriting.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int WORD_W   = 32;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W   = WORD_W - PAGE_LSB;
    localparam int ATTR_LSB = 8;
    localparam int ATTR_W   = 8;
    localparam int PERM_LSB = 16;
    localparam int PERM_W   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [ATTR_W-1:0] attr_t;

    typedef enum logic [2:0] {
        RK_BASE,
        RK_SIZE,
        RK_REMAP,
        RK_ENABLE,
        RK_OVERRIDE,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    parameter int NUM_CH    = 2,
    parameter int TGT_W     = 4,
    parameter int REG_AW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  word_t             reg_wdata,
    output word_t             reg_rdata,
    output page_t             win_base [NUM_WIN],
    output page_t             win_mask [NUM_WIN],
    output attr_t             win_attr [NUM_WIN],
    output logic [TGT_W-1:0]  win_tgt  [NUM_WIN],
    output word_t             chan_en  [NUM_CH]
);

    localparam int SIZE_OFS  = NUM_WIN;
    localparam int REMAP_OFS = 2 * NUM_WIN;
    localparam int EN_OFS    = REMAP_OFS + NUM_REMAP;
    localparam int OVR_OFS   = EN_OFS + NUM_CH;
    localparam int END_OFS   = OVR_OFS + NUM_CH;

    localparam word_t TGT_KEEP  = word_t'((64'd1 << TGT_W) - 64'd1);
    localparam word_t BASE_KEEP = {{(PAGE_W + ATTR_W){1'b1}}, {ATTR_LSB{1'b0}}} | TGT_KEEP;
    localparam word_t SIZE_KEEP = {{PAGE_W{1'b1}}, {PAGE_LSB{1'b0}}};
    localparam word_t EN_KEEP   = word_t'(((64'd1 << (PERM_W * NUM_WIN)) - 64'd1) << PERM_LSB)
                                | word_t'((64'd1 << NUM_WIN) - 64'd1);

    word_t     base_all  [NUM_WIN];
    word_t     size_all  [NUM_WIN];
    word_t     remap_all [NUM_REMAP];
    word_t     en_all    [NUM_CH];
    word_t     ovr_all   [NUM_CH];
    reg_kind_e kind;
    logic [REG_AW-1:0] rel;

    // per-window base and size storage
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        word_t base_r;
        word_t size_r;
        logic  base_sel;
        logic  size_sel;

        assign base_sel = reg_we && (reg_addr == REG_AW'(i));
        assign size_sel = reg_we && (reg_addr == REG_AW'(SIZE_OFS + i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= '0;
                size_r <= '0;
            end else begin
                if (base_sel) base_r <= reg_wdata & BASE_KEEP;
                if (size_sel) size_r <= reg_wdata & SIZE_KEEP;
            end
        end

        assign base_all[i] = base_r;
        assign size_all[i] = size_r;
        assign win_base[i] = base_r[WORD_W-1:PAGE_LSB];
        assign win_mask[i] = size_r[WORD_W-1:PAGE_LSB];
        assign win_attr[i] = base_r[ATTR_LSB +: ATTR_W];
        assign win_tgt[i]  = base_r[TGT_W-1:0];
    end

    // high-remap storage, first NUM_REMAP windows only
    for (genvar r = 0; r < NUM_REMAP; r++) begin : g_remap
        word_t remap_r;
        logic  remap_sel;

        assign remap_sel = reg_we && (reg_addr == REG_AW'(REMAP_OFS + r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         remap_r <= '0;
            else if (remap_sel) remap_r <= reg_wdata;
        end

        assign remap_all[r] = remap_r;
    end

    // per-channel enable and override storage
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        word_t en_r;
        word_t ovr_r;
        logic  en_sel;
        logic  ovr_sel;

        assign en_sel  = reg_we && (reg_addr == REG_AW'(EN_OFS + c));
        assign ovr_sel = reg_we && (reg_addr == REG_AW'(OVR_OFS + c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r  <= '0;
                ovr_r <= '0;
            end else begin
                if (en_sel)  en_r  <= reg_wdata & EN_KEEP;
                if (ovr_sel) ovr_r <= reg_wdata;
            end
        end

        assign en_all[c]  = en_r;
        assign ovr_all[c] = ovr_r;
        assign chan_en[c] = en_r;
    end

    // offset classification
    always_comb begin
        kind = RK_NONE;
        rel  = '0;
        if (reg_addr < REG_AW'(SIZE_OFS)) begin
            kind = RK_BASE;
            rel  = reg_addr;
        end else if (reg_addr < REG_AW'(REMAP_OFS)) begin
            kind = RK_SIZE;
            rel  = reg_addr - REG_AW'(SIZE_OFS);
        end else if (reg_addr < REG_AW'(EN_OFS)) begin
            kind = RK_REMAP;
            rel  = reg_addr - REG_AW'(REMAP_OFS);
        end else if (reg_addr < REG_AW'(OVR_OFS)) begin
            kind = RK_ENABLE;
            rel  = reg_addr - REG_AW'(EN_OFS);
        end else if (reg_addr < REG_AW'(END_OFS)) begin
            kind = RK_OVERRIDE;
            rel  = reg_addr - REG_AW'(OVR_OFS);
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (kind)
            RK_BASE: begin
                for (int i = 0; i < NUM_WIN; i++)
                    if (rel == REG_AW'(i)) reg_rdata = base_all[i];
            end
            RK_SIZE: begin
                for (int i = 0; i < NUM_WIN; i++)
                    if (rel == REG_AW'(i)) reg_rdata = size_all[i];
            end
            RK_REMAP: begin
                for (int r = 0; r < NUM_REMAP; r++)
                    if (rel == REG_AW'(r)) reg_rdata = remap_all[r];
            end
            RK_ENABLE: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (rel == REG_AW'(c)) reg_rdata = en_all[c];
            end
            RK_OVERRIDE: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (rel == REG_AW'(c)) reg_rdata = ovr_all[c];
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  page_t              addr_page,
    input  page_t              win_base [NUM_WIN],
    input  page_t              win_mask [NUM_WIN],
    input  logic [NUM_WIN-1:0] win_on,
    output logic [NUM_WIN-1:0] match
);

    // one masked page comparator per window
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign match[i] = win_on[i] && ((addr_page & ~win_mask[i]) == win_base[i]);
    end

endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
    parameter  int NUM_WIN = 8,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // scan downward so the lowest set index is written last
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
    import awd_pkg::*;
#(
    parameter  int NUM_WIN   = 8,
    parameter  int NUM_REMAP = 4,
    parameter  int NUM_CH    = 2,
    parameter  int TGT_W     = 4,
    localparam int END_OFS   = 2 * NUM_WIN + NUM_REMAP + 2 * NUM_CH,
    localparam int REG_AW    = $clog2(END_OFS + 1),
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       lk_addr,
    input  logic              lk_write,
    input  logic [CH_W-1:0]   lk_chan,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_win,
    output logic [TGT_W-1:0]  lk_target,
    output logic [7:0]        lk_attr,
    output logic              lk_dec_err,
    output logic              lk_perm_err
);

    page_t              win_base [NUM_WIN];
    page_t              win_mask [NUM_WIN];
    attr_t              win_attr [NUM_WIN];
    logic [TGT_W-1:0]   win_tgt  [NUM_WIN];
    word_t              chan_en  [NUM_CH];
    word_t              en_sel;
    logic [NUM_WIN-1:0] match;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic [PERM_W-1:0]  perm;
    logic               unused_low;

    assign unused_low = ^lk_addr[PAGE_LSB-1:0];

    awd_regfile #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .NUM_CH    (NUM_CH),
        .TGT_W     (TGT_W),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_attr  (win_attr),
        .win_tgt   (win_tgt),
        .chan_en   (chan_en)
    );

    // enable register of the requesting channel
    always_comb begin
        en_sel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (lk_chan == CH_W'(c)) en_sel = chan_en[c];
        end
    end

    awd_win_match #(
        .NUM_WIN (NUM_WIN)
    ) u_match (
        .addr_page (lk_addr[WORD_W-1:PAGE_LSB]),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_on    (en_sel[NUM_WIN-1:0]),
        .match     (match)
    );

    awd_prio_pick #(
        .NUM_WIN (NUM_WIN)
    ) u_pick (
        .req   (match),
        .found (found),
        .idx   (pick)
    );

    assign perm = en_sel[PERM_LSB + PERM_W * pick +: PERM_W];

    // result formatting
    always_comb begin
        lk_hit      = found;
        lk_dec_err  = !found;
        lk_win      = '0;
        lk_target   = '0;
        lk_attr     = '0;
        lk_perm_err = 1'b0;
        if (found) begin
            lk_win = pick;
            for (int i = 0; i < NUM_WIN; i++) begin
                if (pick == IDX_W'(i)) begin
                    lk_target = win_tgt[i];
                    lk_attr   = win_attr[i];
                end
            end
            lk_perm_err = lk_write ? !perm[1] : !perm[0];
        end
    end

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter  int NUM_WIN   = 8,
    parameter  int NUM_REMAP = 4,
    parameter  int NUM_CH    = 2,
    parameter  int TGT_W     = 4,
    localparam int END_OFS   = 2 * NUM_WIN + NUM_REMAP + 2 * NUM_CH,
    localparam int REG_AW    = $clog2(END_OFS + 1),
    localparam int REMAP_OFS = 2 * NUM_WIN,
    localparam int OVR_OFS   = REMAP_OFS + NUM_REMAP + NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              lk_hit,
    input logic [TGT_W-1:0]  lk_target,
    input logic [7:0]        lk_attr,
    input logic              lk_dec_err,
    input logic              lk_perm_err
);

    logic full_word_reg;
    assign full_word_reg =
        ((reg_addr >= REG_AW'(REMAP_OFS)) && (reg_addr < REG_AW'(REMAP_OFS + NUM_REMAP)))
     || ((reg_addr >= REG_AW'(OVR_OFS)) && (reg_addr < REG_AW'(OVR_OFS + NUM_CH)));

    AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lk_dec_err && !lk_hit)); // R1

    AST_SIZE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr >= REG_AW'(NUM_WIN)) && (reg_addr < REG_AW'(2 * NUM_WIN)))
        |-> (reg_rdata[15:0] == 16'h0)); // R3

    AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dec_err |-> (lk_target == '0 && lk_attr == 8'h0 && !lk_perm_err)); // R6

    AST_FULL_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && ($past(reg_addr) == reg_addr) && full_word_reg)
        |-> (reg_rdata == $past(reg_wdata))); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= REG_AW'(END_OFS)) |-> (reg_rdata == 32'h0)); // R10

endmodule

bind awd_decoder awd_checker #(
    .NUM_WIN   (NUM_WIN),
    .NUM_REMAP (NUM_REMAP),
    .NUM_CH    (NUM_CH),
    .TGT_W     (TGT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .lk_hit      (lk_hit),
    .lk_target   (lk_target),
    .lk_attr     (lk_attr),
    .lk_dec_err  (lk_dec_err),
    .lk_perm_err (lk_perm_err)
);

// File: tb/awd_decoder_bench.sv
`timescale 1ns/1ps
module awd_decoder_bench;

    localparam int WD_CYCLES = 100000;
    localparam int NV = 12;

    // {addr[31:0], write, chan, hit, win[2:0], tgt[3:0], attr[7:0], perm_err}
    localparam logic [50:0] VEC [NV] = '{
        {32'h1000_0000, 1'b0, 1'b0, 1'b1, 3'd0, 4'd1, 8'h11, 1'b0}, // R4 window 0 low edge
        {32'h10FF_FFFF, 1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 8'h11, 1'b0}, // R4 window 0 top edge
        {32'h1100_0000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 8'h00, 1'b0}, // R6 just past window 0
        {32'h2001_1234, 1'b0, 1'b0, 1'b1, 3'd1, 4'd2, 8'h22, 1'b0}, // R5 windows 1 and 2 overlap
        {32'h2002_0000, 1'b0, 1'b0, 1'b1, 3'd2, 4'd3, 8'h33, 1'b1}, // R7 read refused on window 2
        {32'h2002_0000, 1'b1, 1'b0, 1'b1, 3'd2, 4'd3, 8'h33, 1'b0}, // R7 write allowed on window 2
        {32'hF123_4567, 1'b0, 1'b0, 1'b1, 3'd7, 4'd7, 8'h77, 1'b0}, // R7 read allowed on window 7
        {32'hF123_4567, 1'b1, 1'b0, 1'b1, 3'd7, 4'd7, 8'h77, 1'b1}, // R7 write refused on window 7
        {32'h8000_1000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 8'h00, 1'b0}, // R8 window 5 off for channel 0
        {32'h8000_1000, 1'b1, 1'b1, 1'b1, 3'd5, 4'd5, 8'h55, 1'b0}, // R8 window 5 on for channel 1
        {32'h1000_0000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 8'h00, 1'b0}, // R8 window 0 off for channel 1
        {32'h8001_0000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 8'h00, 1'b0}  // R6 past 64 KiB window 5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic [0:0]  lk_chan = '0;
    logic        lk_hit;
    logic [2:0]  lk_win;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic        lk_dec_err;
    logic        lk_perm_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    awd_decoder u_awd_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .lk_addr     (lk_addr),
        .lk_write    (lk_write),
        .lk_chan     (lk_chan),
        .lk_hit      (lk_hit),
        .lk_win      (lk_win),
        .lk_target   (lk_target),
        .lk_attr     (lk_attr),
        .lk_dec_err  (lk_dec_err),
        .lk_perm_err (lk_perm_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 5'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        reg_addr = 5'(a);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic look(input logic [31:0] a, input logic w, input logic ch);
        lk_addr  = a;
        lk_write = w;
        lk_chan  = ch;
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of registers and lookup
        for (int a = 0; a < 24; a++) rd_chk("R1 reset readback", a, 32'h0);
        look(32'h1000_0000, 1'b0, 1'b0);
        chk("R1 reset lk_dec_err", lk_dec_err, 1);
        chk("R1 reset lk_hit", lk_hit, 0);

        // R2 / R3 / R8: field masking on readback
        wr(3, 32'hFFFF_FFFF);
        rd_chk("R2 base field mask", 3, 32'hFFFF_FF0F);
        wr(11, 32'hFFFF_FFFF);
        rd_chk("R3 size low bits clear", 11, 32'hFFFF_0000);
        wr(20, 32'hFFFF_FFFF);
        rd_chk("R8 enable reserved bits clear", 20, 32'hFFFF_00FF);
        wr(3, 32'h0);
        wr(11, 32'h0);
        wr(20, 32'h0);

        // R9: full-word registers
        wr(16, 32'hDEAD_BEEF);
        wr(19, 32'h1234_5678);
        wr(22, 32'hA5A5_A5A5);
        wr(23, 32'h5A5A_5A5A);
        rd_chk("R9 remap window 0", 16, 32'hDEAD_BEEF);
        rd_chk("R9 remap window 3", 19, 32'h1234_5678);
        rd_chk("R9 override channel 0", 22, 32'hA5A5_A5A5);
        rd_chk("R9 override channel 1", 23, 32'h5A5A_5A5A);

        // R10: unmapped offsets
        wr(24, 32'hFFFF_FFFF);
        wr(31, 32'hFFFF_FFFF);
        rd_chk("R10 offset 24 reads zero", 24, 32'h0);
        rd_chk("R10 offset 31 reads zero", 31, 32'h0);
        rd_chk("R10 base 0 untouched", 0, 32'h0);
        rd_chk("R10 size 0 untouched", 8, 32'h0);
        rd_chk("R10 remap 0 untouched", 16, 32'hDEAD_BEEF);
        rd_chk("R10 enable 0 untouched", 20, 32'h0);
        look(32'hFFFF_0000, 1'b0, 1'b0);
        chk("R10 lookup still misses", lk_dec_err, 1);

        // window setup
        wr(0,  32'h1000_1101);  wr(8,  32'h00FF_0000);
        wr(1,  32'h2001_2202);  wr(9,  32'h0000_0000);
        wr(2,  32'h2000_3303);  wr(10, 32'h0FFF_0000);
        wr(5,  32'h8000_5505);  wr(13, 32'h0000_0000);
        wr(7,  32'hF000_7707);  wr(15, 32'h0FFF_0000);
        wr(20, 32'h402F_0087);
        wr(21, 32'h0C00_0020);
        rd_chk("R8 enable channel 0", 20, 32'h402F_0087);
        rd_chk("R8 enable channel 1", 21, 32'h0C00_0020);

        // vector table: R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            look(VEC[k][50:19], VEC[k][18], VEC[k][17]);
            chk($sformatf("R4 vector %0d lk_hit", k), lk_hit, VEC[k][16]);
            chk($sformatf("R6 vector %0d lk_dec_err", k), lk_dec_err, !VEC[k][16]);
            chk($sformatf("R5 vector %0d lk_win", k), lk_win, VEC[k][15:13]);
            chk($sformatf("R4 vector %0d lk_target", k), lk_target, VEC[k][12:9]);
            chk($sformatf("R4 vector %0d lk_attr", k), lk_attr, VEC[k][8:1]);
            chk($sformatf("R7 vector %0d lk_perm_err", k), lk_perm_err, VEC[k][0]);
        end

        // R11: write and lookup in the same cycle
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 5'd0;
        reg_wdata = 32'h3000_1101;
        look(32'h1000_0000, 1'b0, 1'b0);
        chk("R11 old window still hits during write", lk_hit, 1);
        chk("R11 old window index during write", lk_win, 0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R11 old range misses after write", lk_dec_err, 1);
        look(32'h30AB_CDEF, 1'b1, 1'b0);
        chk("R11 new range hits after write", lk_hit, 1);
        chk("R11 new range window index", lk_win, 0);
        chk("R11 new range target", lk_target, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule